// File: doc/BRIEF.md
# USB Bus Reset Detector

The block watches the two synchronized USB data line levels and recognises a bus reset: a single-ended zero (both lines low) that lasts longer than a programmable number of clock cycles. Software loads the threshold as the wanted minimum time (about 2.5 µs) multiplied by the clock frequency. Once the condition has outlasted the threshold, the block does one of two things, chosen by a configuration bit. It holds an internal reset request for as long as the bus stays in reset, or it sets a sticky interrupt flag that software clears by writing 1.

When the single-ended zero ends after a detection, the block gives a one-cycle end-of-reset pulse. A device-state tracker uses this pulse to return to the attached, unaddressed and unconfigured state, and must be able to take a new address within 10 ms of it. While the module enable is clear, the block is inert: its counter, its state and all of its outputs are held at zero.

Top module: `usb_bus_reset_det`

## Requirements
- R1: A single-ended zero is a cycle in which `enable` is 1 and both `dp` and `dm` are 0. The duration count restarts from zero in any cycle in which either line is 1.
- R2: A detection happens on the clock edge at which the single-ended zero has been sampled for `threshold`+1 consecutive edges. A run of `threshold` edges or fewer produces no change on any output.
- R3: If `route_irq` is 0 at the detecting edge, `reset_req` is 1 from that edge until the first edge at which the single-ended zero is no longer seen. At that edge it returns to 0.
- R4: If `route_irq` is 1 at the detecting edge, `irq_flag` becomes 1 at that edge and `reset_req` stays 0.
- R5: `route_irq` is sampled only at the detecting edge. Changing it later in the same bus reset has no effect on `reset_req` or `irq_flag`.
- R6: A single-ended zero of any length past the threshold gives exactly one detection. An `irq_flag` cleared during that run stays 0 until the run ends.
- R7: `irq_flag` holds its value until an edge with `irq_clr` at 1 clears it. If a clear and a new detection fall on the same edge, the flag is 1 afterwards.
- R8: `reset_end` is 1 for exactly one cycle, after the first edge at which the single-ended zero is gone following a detection. It stays 0 after runs that did not reach detection.
- R9: An edge with `enable` at 0 clears the count, the bus-reset state and `irq_flag`. After that edge, `reset_req`, `irq_flag` and `reset_end` are all 0, and disabling produces no `reset_end` pulse.
- R10: After reset (`rst_n` low), `reset_req`, `irq_flag` and `reset_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | USB module enable; 0 gates the block off |
| route_irq | input | 1 | 1 sends a detection to the interrupt flag, 0 to the reset request |
| dp | input | 1 | Synchronized D+ line level |
| dm | input | 1 | Synchronized D- line level |
| threshold | input | CNT_W | Single-ended-zero length in cycles that must be exceeded |
| irq_clr | input | 1 | Write-1 clear strobe for the interrupt flag |
| reset_req | output | 1 | Internal reset request, held during a detected bus reset |
| irq_flag | output | 1 | Sticky bus-reset interrupt flag |
| reset_end | output | 1 | One-cycle pulse when a detected bus reset ends |

## Verification
The hardest situation to reach from the ports is a clear strobe on the same edge as a new detection. The single-ended zero must have run for exactly `threshold`+1 edges when `irq_clr` arrives, with an old flag still set from an earlier reset. The bench reaches this with a directed sequence that counts the edges and times the strobe, and random stimulus adds further cases. The random part uses small thresholds and long single-ended-zero runs, with `route_irq` toggling during the runs, so that saturation, one-detection-per-run and mode latching are all exercised often.

// File: rtl/usb_bus_reset_det.sv
module usb_bus_reset_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             route_irq,
  input  logic             dp,
  input  logic             dm,
  input  logic [CNT_W-1:0] threshold,
  input  logic             irq_clr,
  output logic             reset_req,
  output logic             irq_flag,
  output logic             reset_end
);

  logic [CNT_W-1:0] cnt;
  logic             active;
  logic             mode_irq;
  logic             se0;
  logic             reached;
  logic             hit;

  assign se0     = enable & ~dp & ~dm;
  assign reached = cnt >= threshold;
  assign hit     = se0 & ~active & reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!se0) begin
      cnt <= '0;
    end else if (!reached) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      mode_irq  <= 1'b0;
      irq_flag  <= 1'b0;
      reset_end <= 1'b0;
    end else begin
      active    <= se0 & (active | hit);
      reset_end <= enable & active & ~se0;
      if (hit) mode_irq <= route_irq;
      if (!enable)
        irq_flag <= 1'b0;
      else if (hit && route_irq)
        irq_flag <= 1'b1;
      else if (irq_clr)
        irq_flag <= 1'b0;
    end
  end

  assign reset_req = active & ~mode_irq;

endmodule

module usb_bus_reset_det_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic dp,
  input logic dm,
  input logic irq_clr,
  input logic active,
  input logic reset_req,
  input logic irq_flag,
  input logic reset_end
);

  // R8
  a_r8_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_end |=> !reset_end);

  // R8
  a_r8_end_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_end) |-> $past(active));

  // R9
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!reset_req && !irq_flag && !reset_end));

  // R1
  a_r1_line_high_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (dp || dm) |=> !reset_req);

  // R7
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && enable && !irq_clr) |=> irq_flag);

  // R6
  a_r6_one_detection: assert property (@(posedge clk) disable iff (!rst_n)
    (active && enable && !dp && !dm) |=> !$rose(irq_flag));

endmodule

bind usb_bus_reset_det usb_bus_reset_det_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .dp(dp), .dm(dm),
  .irq_clr(irq_clr), .active(active), .reset_req(reset_req),
  .irq_flag(irq_flag), .reset_end(reset_end)
);

// File: tb/tb_usb_bus_reset_det.sv
module tb_usb_bus_reset_det;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, route_irq = 1'b0, dp = 1'b1, dm = 1'b0, irq_clr = 1'b0;
  logic [CNT_W-1:0] threshold = 16'd5;
  logic reset_req, irq_flag, reset_end;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference state derived from the requirements
  int m_run = 0;
  bit m_det = 1'b0, m_mode = 1'b0, m_irq = 1'b0, m_end = 1'b0;

  always #4 clk = ~clk;

  usb_bus_reset_det #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .route_irq(route_irq),
    .dp(dp), .dm(dm), .threshold(threshold), .irq_clr(irq_clr),
    .reset_req(reset_req), .irq_flag(irq_flag), .reset_end(reset_end)
  );

  function automatic bit is_se0(bit en, bit p, bit m);
    return en && !p && !m;
  endfunction

  function automatic bit exp_req(bit det, bit mode);
    return det && !mode;
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit s = is_se0(enable, dp, dm);
    bit hit = s && !m_det && (m_run >= int'(threshold));
    m_end = enable && m_det && !s;
    if (!enable) m_irq = 1'b0;
    else if (hit && route_irq) m_irq = 1'b1;
    else if (irq_clr) m_irq = 1'b0;
    if (hit) m_mode = route_irq;
    m_det = s && (m_det || hit);
    if (!s) m_run = 0;
    else if (m_run < int'(threshold)) m_run++;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R3", reset_req, exp_req(m_det, m_mode));
    check("R7", irq_flag, m_irq);
    check("R8", reset_end, m_end);
  endtask

  task automatic se0_run(int n);
    for (int i = 0; i < n; i++) begin dp = 1'b0; dm = 1'b0; step(); end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin dp = 1'b1; dm = 1'b0; step(); end
  endtask

  initial begin
    #200000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R10", reset_req, 1'b0);
    check("R10", irq_flag, 1'b0);
    check("R10", reset_end, 1'b0);
    rst_n = 1'b1;
    enable = 1'b1;
    idle(2);

    // R2: run of exactly threshold edges -> nothing
    threshold = 16'd5; route_irq = 1'b0;
    se0_run(5);
    check("R2 short", reset_req, 1'b0);
    idle(1);
    check("R2 no end", reset_end, 1'b0);

    // R1: one line high splits the run
    se0_run(4); dp = 1'b0; dm = 1'b1; step(); se0_run(4);
    check("R1 restart", reset_req, 1'b0);
    idle(1);

    // R3/R5: threshold+1 -> reset request; route change ignored
    se0_run(5);
    check("R2 before", reset_req, 1'b0);
    se0_run(1);
    check("R3 req", reset_req, 1'b1);
    route_irq = 1'b1;
    se0_run(20);
    check("R5 latched", reset_req, 1'b1);
    check("R5 no irq", irq_flag, 1'b0);
    idle(1);
    check("R3 release", reset_req, 1'b0);
    check("R8 pulse", reset_end, 1'b1);
    idle(1);
    check("R8 one cycle", reset_end, 1'b0);

    // R4/R6: interrupt route, long run, clear mid-run
    route_irq = 1'b1;
    se0_run(6);
    check("R4 flag", irq_flag, 1'b1);
    check("R4 no req", reset_req, 1'b0);
    irq_clr = 1'b1; se0_run(1); irq_clr = 1'b0;
    check("R7 cleared", irq_flag, 1'b0);
    se0_run(30);
    check("R6 single", irq_flag, 1'b0);
    idle(2);

    // R7: clear on the detecting edge with an old flag set
    se0_run(6); idle(1);
    check("R7 old set", irq_flag, 1'b1);
    se0_run(5); irq_clr = 1'b1; se0_run(1); irq_clr = 1'b0;
    check("R7 set wins", irq_flag, 1'b1);
    idle(1);

    // R9: disable during a bus reset
    route_irq = 1'b0;
    se0_run(8);
    check("R9 pre", reset_req, 1'b1);
    enable = 1'b0; step();
    check("R9 req", reset_req, 1'b0);
    check("R9 irq", irq_flag, 1'b0);
    check("R9 no end", reset_end, 1'b0);
    se0_run(10);
    check("R9 gated", reset_req, 1'b0);
    enable = 1'b1; idle(1);

    // threshold zero: first SE0 edge detects (R2)
    threshold = 16'd0;
    se0_run(1);
    check("R2 zero thr", reset_req, 1'b1);
    idle(2);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 400 == 0) threshold = 16'($urandom_range(0, 12));
      if ($urandom_range(0, 9) < 7) begin dp = 1'b0; dm = 1'b0; end
      else begin dp = 1'($urandom); dm = ~dp | 1'($urandom); end
      if ($urandom_range(0, 15) == 0) route_irq = ~route_irq;
      irq_clr = ($urandom_range(0, 11) == 0);
      enable = ($urandom_range(0, 49) != 0);
      step();
    end
    irq_clr = 1'b0; enable = 1'b1;
    idle(3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule